// File: doc/BRIEF.md
# Priority Interrupt Controller with In-Service Tracking

This block arbitrates a set of interrupt request lines for a single processor core. For each line it keeps a one-bit request flag and a one-bit in-service flag. A request flag is set by a rising edge on the line. The controller looks for the most urgent line, and line 0 is the most urgent. It signals the core on a single interrupt output. When the core acknowledges, the winning line's request flag moves into its in-service flag and the line's index appears on the vector output.

The scan runs from index 0 upward and stops at the first line that has an unmasked request or is in service. As a result, a line that is in service holds off every line below it until software sends an end-of-interrupt. A request on a more urgent line still reaches the core, so handlers can nest. Each end-of-interrupt retires the most urgent level that is still in service.

While a line is in service it can hold one further request in its request flag. Any later edges on that line are dropped. A per-line mask register removes a line from the scan but still records its edges, so unmasking a line releases a request that is already waiting.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0, no request or in-service flag is set, and no line is masked.
- R2: Only a 0-to-1 transition of `irq_req_i[k]` sets request flag k. `irq_o` rises in the cycle after the clock edge that sees the transition. Holding the line high afterwards creates no further request.
- R3: When several lines qualify, the lowest index wins, and that index is what `vec_o` shows after the acknowledge.
- R4: An acknowledge while `irq_o` is 1 clears the winner's request flag, sets its in-service flag, and loads its index into `vec_o` at the same clock edge. `vec_o` holds that value until the next accepted acknowledge.
- R5: While line k is in service, no request on a line with index greater than k raises `irq_o`.
- R6: A request on a line with an index below every in-service line raises `irq_o`, which allows nested service.
- R7: `eoi_i` clears the in-service flag with the lowest index. If a request is then eligible, `irq_o` is 1 in the following cycle.
- R8: While a line is in service it keeps at most one further request. Any additional edges in that period are lost, so after the end-of-interrupt exactly one more service of that line follows.
- R9: Writing `mask_wdata_i` with `mask_we_i` sets the mask, where bit k = 1 masks line k. A masked line is not a candidate, but its edges are still recorded, and clearing its mask bit makes a waiting request eligible.
- R10: An acknowledge while `irq_o` is 0 changes nothing: `vec_o` and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | NUM_LINES | Interrupt request lines, edge sensitive |
| mask_we_i | input | 1 | Load enable for the mask register |
| mask_wdata_i | input | NUM_LINES | New mask value, 1 = masked |
| ack_i | input | 1 | Core acknowledge |
| eoi_i | input | 1 | End-of-interrupt from software |
| irq_o | output | 1 | Interrupt to the core |
| vec_o | output | VEC_W | Index of the most recently acknowledged line |

## Verification
The directed cases go after the spots where a faulty scan gives itself away.

- **In-service line with lower-priority requests behind it.** Line 3 is in service while lines 4 and 6 wait. A scan that skips in-service lines would raise the interrupt early.
- **Nested service.** A more urgent line arrives during service of line 6. A controller that blocks on any in-service flag would never nest. Once the nested level is retired, line 7 must still be held off by line 6; an end-of-interrupt that cleared the wrong level would let line 7 through.
- **Repeated pulses during service.** These must leave exactly one extra service. Counting them would grant one service per pulse; dropping all of them would grant none.
- **Masking and stray acknowledges.** A masked line must not fire but must still record its edge. An acknowledge with no interrupt pending must leave the vector unchanged.

Long random runs then compare every cycle against a bench model of the flags.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int unsigned DEF_LINES = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] rise_o
);

  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= req_i;
  end

  always_comb begin
    rise_o = req_i & ~prev_q;
  end

endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] isr_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic [NUM_LINES-1:0] grant_o,
  output logic                 valid_o,
  output logic [VEC_W-1:0]     idx_o
);

  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] stop;
  logic [NUM_LINES:0]   clear_above;

  always_comb begin
    cand = pend_i & ~mask_i;
    stop = cand | isr_i;
  end

  assign clear_above[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_chain
      assign clear_above[g+1] = clear_above[g] & ~stop[g];
      assign grant_o[g]       = clear_above[g] & cand[g] & ~isr_i[g];

      // R5: an in-service line shuts off grants at and below it
      a_r5_isr_blocks_lower: assert property (@(posedge clk) disable iff (!rst_n)
        isr_i[g] |-> ((grant_o >> g) == '0));
    end
  endgenerate

  always_comb begin
    valid_o = |grant_o;
    idx_o   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (grant_o[i]) idx_o = idx_o | VEC_W'(i);
    end
  end

  // R3: at most one line wins
  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] take_i,
  input  logic                 eoi_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] isr_o
);

  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] isr_q,  isr_d;
  logic [NUM_LINES-1:0] eoi_clr;
  logic                 pend_en, isr_en;

  always_comb begin
    eoi_clr = eoi_i ? (isr_q & (~isr_q + NUM_LINES'(1))) : '0;
    pend_en = (|rise_i) | (|take_i);
    isr_en  = (|take_i) | (|eoi_clr);
    pend_d  = (pend_q & ~take_i) | rise_i;
    isr_d   = (isr_q & ~eoi_clr) | take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end

  assign pend_o = pend_q;
  assign isr_o  = isr_q;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_chk
      // R2: a request flag only appears after an edge on its line
      a_r2_pend_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[g]) |-> $past(rise_i[g]));
      // R4: an in-service flag only appears after an accepted acknowledge
      a_r4_isr_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_q[g]) |-> $past(take_i[g]));
    end
  endgenerate

  // R7: an end-of-interrupt without acknowledge retires exactly one level
  a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && (take_i == '0) && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q))));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = DEF_LINES,
  parameter int unsigned VEC_W     = idx_width(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req_i,
  input  logic                 mask_we_i,
  input  logic [NUM_LINES-1:0] mask_wdata_i,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     vec_o
);

  logic                 rst_n_s;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] pend, isr, grant, take;
  logic [NUM_LINES-1:0] mask_q, mask_d;
  logic                 win_valid;
  logic [VEC_W-1:0]     win_idx;
  logic [VEC_W-1:0]     vec_q, vec_d;
  logic                 ack_fire;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  irq_edge_det #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .req_i  (irq_req_i),
    .rise_o (rise)
  );

  irq_prio_scan #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pend_i  (pend),
    .isr_i   (isr),
    .mask_i  (mask_q),
    .grant_o (grant),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  irq_line_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rise_i (rise),
    .take_i (take),
    .eoi_i  (eoi_i),
    .pend_o (pend),
    .isr_o  (isr)
  );

  always_comb begin
    ack_fire = ack_i & win_valid;
    take     = ack_fire ? grant : '0;
    vec_d    = win_idx;
    mask_d   = mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      vec_q <= '0;
    else if (ack_fire) vec_q <= vec_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d;
  end

  assign irq_o = win_valid;
  assign vec_o = vec_q;

  // R4: the reported vector names a line now in service
  a_r4_vec_in_service: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_fire |=> isr[vec_o]);

  // R10: an acknowledge with nothing to grant leaves the vector alone
  a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_i && !irq_o) |=> $stable(vec_o));

  // R9: a masked line never drives the interrupt by itself
  a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((pend & ~mask_q) == '0) |-> !irq_o);

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;

  localparam int unsigned N      = 8;
  localparam int unsigned VW     = 3;
  localparam time         CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          mwe;
  logic [N-1:0]  mwd;
  logic          ack;
  logic          eoi;
  logic          irq;
  logic [VW-1:0] vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [N-1:0]  m_pend, m_isr, m_mask, m_prev;
  logic [VW-1:0] m_vec;

  always #(CLK_PER/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(N), .VEC_W(VW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req_i    (req),
    .mask_we_i    (mwe),
    .mask_wdata_i (mwd),
    .ack_i        (ack),
    .eoi_i        (eoi),
    .irq_o        (irq),
    .vec_o        (vec)
  );

  // returns {valid, index}
  function automatic logic [VW:0] m_scan();
    for (int i = 0; i < N; i++) begin
      if (m_isr[i]) return '0;
      if (m_pend[i] && !m_mask[i]) return {1'b1, VW'(i)};
    end
    return '0;
  endfunction

  function automatic logic [N-1:0] m_lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // predict the effect of the driven inputs at the coming edge
  task automatic model_step();
    logic [VW:0]  s;
    logic [N-1:0] take, rise, clr;
    s    = m_scan();
    take = (ack && s[VW]) ? (N'(1) << s[VW-1:0]) : '0;
    rise = req & ~m_prev;
    clr  = eoi ? m_lowest(m_isr) : '0;
    if (ack && s[VW]) m_vec = s[VW-1:0];
    m_pend = (m_pend & ~take) | rise;
    m_isr  = (m_isr & ~clr) | take;
    if (mwe) m_mask = mwd;
    m_prev = req;
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic a, input logic e,
                     input logic w, input logic [N-1:0] md, input string tag);
    logic [VW:0] s;
    req = r; ack = a; eoi = e; mwe = w; mwd = md;
    model_step();
    @(posedge clk);
    @(negedge clk);
    s = m_scan();
    chk(tag, 32'(irq), 32'(s[VW]));
    chk(tag, 32'(vec), 32'(m_vec));
  endtask

  task automatic idle(input logic [N-1:0] r, input string tag);
    cyc(r, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic do_ack(input logic [N-1:0] r, input string tag);
    cyc(r, 1'b1, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic do_eoi(input logic [N-1:0] r, input string tag);
    cyc(r, 1'b0, 1'b1, 1'b0, '0, tag);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req = '0; ack = 0; eoi = 0; mwe = 0; mwd = '0;
    m_pend = '0; m_isr = '0; m_mask = '0; m_prev = '0; m_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle('0, "R1");
    chk("R1", 32'(irq), 0);
    chk("R1", 32'(vec), 0);

    // R2: edge sets the request, a held level does not add another
    idle(8'h20, "R2");
    chk("R2", 32'(irq), 1);
    idle(8'h20, "R2");
    do_ack(8'h20, "R4");
    chk("R4", 32'(vec), 5);
    chk("R4", 32'(irq), 0);
    idle(8'h20, "R2");
    idle(8'h20, "R2");
    chk("R2", 32'(irq), 0);
    do_eoi(8'h20, "R7");
    chk("R2", 32'(irq), 0);
    idle('0, "R2");

    // R3 then R5: lines 3, 4 and 6 together
    idle(8'h58, "R3");
    do_ack('0, "R3");
    chk("R3", 32'(vec), 3);
    chk("R5", 32'(irq), 0);
    idle('0, "R5");
    chk("R5", 32'(irq), 0);
    do_eoi('0, "R7");
    chk("R7", 32'(irq), 1);
    do_ack('0, "R3");
    chk("R3", 32'(vec), 4);
    do_eoi('0, "R7");
    do_ack('0, "R3");
    chk("R3", 32'(vec), 6);
    do_eoi('0, "R7");
    chk("R7", 32'(irq), 0);

    // R6: nesting
    idle(8'h40, "R6");
    do_ack('0, "R6");
    idle(8'h02, "R6");
    chk("R6", 32'(irq), 1);
    do_ack('0, "R6");
    chk("R6", 32'(vec), 1);
    do_eoi('0, "R7");
    idle(8'h80, "R7");
    chk("R7", 32'(irq), 0);
    do_eoi('0, "R7");
    chk("R7", 32'(irq), 1);
    do_ack('0, "R7");
    chk("R7", 32'(vec), 7);
    do_eoi('0, "R7");

    // R8: repeated pulses during service leave one extra request
    idle(8'h04, "R8");
    do_ack('0, "R8");
    for (int k = 0; k < 3; k++) begin
      idle(8'h04, "R8");
      idle('0, "R8");
    end
    chk("R8", 32'(irq), 0);
    do_eoi('0, "R8");
    chk("R8", 32'(irq), 1);
    do_ack('0, "R8");
    chk("R8", 32'(vec), 2);
    do_eoi('0, "R8");
    chk("R8", 32'(irq), 0);

    // R9: masked line records but does not fire
    cyc('0, 1'b0, 1'b0, 1'b1, 8'h01, "R9");
    idle(8'h01, "R9");
    idle('0, "R9");
    chk("R9", 32'(irq), 0);
    cyc('0, 1'b0, 1'b0, 1'b1, 8'h00, "R9");
    chk("R9", 32'(irq), 1);
    do_ack('0, "R9");
    chk("R9", 32'(vec), 0);
    do_eoi('0, "R9");

    // R10: stray acknowledge
    do_ack('0, "R10");
    chk("R10", 32'(vec), 0);
    chk("R10", 32'(irq), 0);

    // random traffic against the model
    for (int t = 0; t < 4000; t++) begin
      logic [N-1:0] r;
      logic [N-1:0] flip;
      flip = '0;
      for (int b = 0; b < N; b++) flip[b] = (($urandom % 8) == 0);
      r = req ^ flip;
      cyc(r, (($urandom % 3) == 0), (($urandom % 4) == 0),
          (($urandom % 25) == 0), N'($urandom) & N'($urandom), "R3");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule